// File: doc/BRIEF.md
# Audio master and bit clock divider

This block derives two audio clocks from a single module clock. The first is a master-clock enable, a one-cycle strobe repeated once per master-clock period. The second is a bit-clock square wave with separate rising and falling strobes. The strobes let a serializer launch and capture data without crossing into a derived clock domain. Each divide ratio is chosen by a small code rather than a binary count, so ratios such as 6, 12 and 24 are reachable. Codes outside the tables raise an error flag and stop the clocks.

One 8-bit control word, `cfg_word`, configures the block:
- bits 3:0 hold the master-clock code;
- bits 6:4 hold the bit-clock code;
- bit 7 gates the master-clock strobe.

A new pair of codes is adopted only at the end of a complete bit-clock period, and both dividers restart from zero at that point. A ratio change therefore never produces a shortened high or low phase.

The control is a three-state machine:
- **IDLE** is entered from reset.
- **RUN** counts.
- **FAULT** holds every clock output low.

The transitions are:
- **IDLE→RUN** (load) when the control word is legal.
- **IDLE→FAULT** (reject) when it is not.
- **RUN→FAULT** (trip) when the word is illegal at the end of a bit-clock period.
- **RUN→RUN** (reload) at the end of a period when the word is legal.
- **FAULT→RUN** (recover) as soon as the word becomes legal.

Top module: `audclk_divider`

## Requirements
- R1: While reset is asserted, `mclk_ce`, `bclk_lvl`, `bclk_rise`, `bclk_fall` and `cfg_err` are all low.
- R2: The master-clock code in `cfg_word[3:0]` selects a ratio M as follows: 0→1, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→24. `mclk_ce` pulses once every M module-clock cycles; with code 0 it is high on every cycle.
- R3: The bit-clock code in `cfg_word[6:4]` selects a ratio B of master-clock periods as follows: 0→2, 1→4, 2→6, 3→8, 4→12, 5→16. `bclk_lvl` has a period of M·B module cycles at exactly 50% duty. Each period starts low.
- R4: `bclk_rise` (or `bclk_fall`) is high for exactly the one cycle in which `bclk_lvl` first shows its new high (or low) value. The two strobes are never high together.
- R5: When `cfg_word[7]` is low, `mclk_ce` is low from the next cycle onward. `bclk_lvl` keeps running.
- R6: `cfg_err` is high, one cycle after the word is presented, exactly when the master-clock code is 8–15 or the bit-clock code is 6–7.
- R7: An illegal word at the end of a bit-clock period, or out of reset, enters FAULT. In FAULT all clock outputs are low and static.
- R8: The exit from FAULT, or from IDLE, to RUN happens on the next edge once the word is legal. The first `bclk_rise` then appears M·B/2+1 cycles after the word is presented.
- R9: A code change while running takes effect only after the current bit-clock period completes. The period in progress keeps its old high and low lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 8 | Master code [3:0], bit code [6:4], master enable [7] |
| mclk_ce | output | 1 | Master-clock enable strobe |
| bclk_lvl | output | 1 | Bit-clock square wave |
| bclk_rise | output | 1 | Strobe in the first cycle of bit-clock high |
| bclk_fall | output | 1 | Strobe in the first cycle of bit-clock low |
| cfg_err | output | 1 | Illegal code present in the control word |

## Verification
Every legal master-clock code is swept, each paired with a different bit-clock code. The measured strobe gap and bit-clock high and low lengths separate table errors from duty-cycle errors. A word with the enable bit cleared shows whether gating touches the bit-clock chain. Illegal master and bit codes, followed by a legal restart, tell a correct FAULT hold apart from one that leaks edges or restarts mid-count. A code change placed right after a rising strobe distinguishes a load at the end of the period from an immediate load.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int MCODE_W_DEF = 4;
    localparam int BCODE_W_DEF = 3;
    localparam int M_MAX_DEF   = 24;
    localparam int B_MAX_DEF   = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } dstate_t;

    // Master-clock ratio per code; 0 marks an undefined code.
    function automatic int unsigned mclk_ratio(input logic [7:0] code);
        unique case (code)
            8'd0:    return 1;
            8'd1:    return 2;
            8'd2:    return 4;
            8'd3:    return 6;
            8'd4:    return 8;
            8'd5:    return 12;
            8'd6:    return 16;
            8'd7:    return 24;
            default: return 0;
        endcase
    endfunction

    // Bit-clock ratio (in master-clock periods) per code; 0 marks undefined.
    function automatic int unsigned bclk_ratio(input logic [7:0] code);
        unique case (code)
            8'd0:    return 2;
            8'd1:    return 4;
            8'd2:    return 6;
            8'd3:    return 8;
            8'd4:    return 12;
            8'd5:    return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/audclk_decode.sv
module audclk_decode
    import audclk_pkg::*;
#(
    parameter int MCODE_W = MCODE_W_DEF,
    parameter int BCODE_W = BCODE_W_DEF,
    parameter int MR_W    = 5,
    parameter int BR_W    = 5
) (
    input  logic [MCODE_W-1:0] m_code,
    input  logic [BCODE_W-1:0] b_code,
    output logic [MR_W-1:0]    m_ratio,
    output logic [BR_W-1:0]    b_ratio,
    output logic               m_ok,
    output logic               b_ok
);

    int unsigned m_raw;
    int unsigned b_raw;

    always_comb begin
        m_raw   = mclk_ratio(8'(m_code));
        b_raw   = bclk_ratio(8'(b_code));
        m_ok    = (m_raw != 0);
        b_ok    = (b_raw != 0);
        m_ratio = MR_W'(m_raw);
        b_ratio = BR_W'(b_raw);
    end

endmodule

// File: rtl/audclk_mdiv.sv
module audclk_mdiv #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio,
    output logic          tick
);

    logic [RW-1:0] count_q;

    // Terminal count of the module-clock prescaler; with ratio 1 the
    // counter stays at zero and the tick is held high.
    assign tick = run && (count_q == (ratio - RW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + RW'(1);
        end
    end

endmodule

// File: rtl/audclk_bdiv.sv
module audclk_bdiv #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          adv,
    input  logic [RW-1:0] ratio,
    output logic          half_hit,
    output logic          end_hit
);

    logic [RW-1:0] count_q;

    // Ratios are always even, so the midpoint falls on a whole tick.
    assign half_hit = run && adv && (count_q == ((ratio >> 1) - RW'(1)));
    assign end_hit  = run && adv && (count_q == (ratio - RW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run) begin
            count_q <= '0;
        end else if (end_hit) begin
            count_q <= '0;
        end else if (adv) begin
            count_q <= count_q + RW'(1);
        end
    end

endmodule

// File: rtl/audclk_divider.sv
module audclk_divider
    import audclk_pkg::*;
#(
    parameter int MCODE_W = MCODE_W_DEF,
    parameter int BCODE_W = BCODE_W_DEF,
    parameter int M_MAX   = M_MAX_DEF,
    parameter int B_MAX   = B_MAX_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [MCODE_W+BCODE_W:0]   cfg_word,
    output logic                       mclk_ce,
    output logic                       bclk_lvl,
    output logic                       bclk_rise,
    output logic                       bclk_fall,
    output logic                       cfg_err
);

    localparam int EN_BIT = MCODE_W + BCODE_W;
    localparam int MR_W   = $clog2(M_MAX + 1);
    localparam int BR_W   = $clog2(B_MAX + 1);

    dstate_t         state_q, state_d;
    logic [MR_W-1:0] m_dec, m_act_q;
    logic [BR_W-1:0] b_dec, b_act_q;
    logic            m_ok, b_ok, legal;
    logic            running, mtick, half_hit, end_hit, load;

    audclk_decode #(
        .MCODE_W (MCODE_W),
        .BCODE_W (BCODE_W),
        .MR_W    (MR_W),
        .BR_W    (BR_W)
    ) u_decode (
        .m_code  (cfg_word[MCODE_W-1:0]),
        .b_code  (cfg_word[EN_BIT-1:MCODE_W]),
        .m_ratio (m_dec),
        .b_ratio (b_dec),
        .m_ok    (m_ok),
        .b_ok    (b_ok)
    );

    assign legal   = m_ok && b_ok;
    assign running = (state_q == ST_RUN);

    audclk_mdiv #(.RW(MR_W)) u_mdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .ratio (m_act_q),
        .tick  (mtick)
    );

    audclk_bdiv #(.RW(BR_W)) u_bdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .adv      (mtick),
        .ratio    (b_act_q),
        .half_hit (half_hit),
        .end_hit  (end_hit)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = legal ? ST_RUN : ST_FAULT;
            ST_FAULT: state_d = legal ? ST_RUN : ST_FAULT;
            ST_RUN:   state_d = (end_hit && !legal) ? ST_FAULT : ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    // New ratios are accepted from a stopped state or at a bit-clock period end.
    assign load = legal && (!running || end_hit);

    // State register and the active ratio pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            m_act_q <= MR_W'(1);
            b_act_q <= BR_W'(2);
        end else begin
            state_q <= state_d;
            if (load) begin
                m_act_q <= m_dec;
                b_act_q <= b_dec;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_ce   <= 1'b0;
            bclk_lvl  <= 1'b0;
            bclk_rise <= 1'b0;
            bclk_fall <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            mclk_ce   <= mtick && cfg_word[EN_BIT];
            bclk_rise <= half_hit;
            bclk_fall <= end_hit;
            cfg_err   <= !legal;
            if (!running || end_hit) begin
                bclk_lvl <= 1'b0;
            end else if (half_hit) begin
                bclk_lvl <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/audclk_divider_chk.sv
module audclk_divider_chk
    import audclk_pkg::*;
#(
    parameter int MCODE_W = MCODE_W_DEF,
    parameter int BCODE_W = BCODE_W_DEF
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [MCODE_W+BCODE_W:0] cfg_word,
    input logic                     mclk_ce,
    input logic                     bclk_lvl,
    input logic                     bclk_rise,
    input logic                     bclk_fall,
    input logic                     cfg_err,
    input dstate_t                  state_q
);

    logic bad_word;
    always_comb begin
        bad_word = (mclk_ratio(8'(cfg_word[MCODE_W-1:0])) == 0) ||
                   (bclk_ratio(8'(cfg_word[MCODE_W+BCODE_W-1:MCODE_W])) == 0);
    end

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall));

    assert_rise_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> (bclk_lvl && !$past(bclk_lvl)));

    assert_fall_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> (!bclk_lvl && $past(bclk_lvl)));

    assert_edge_strobed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_lvl != $past(bclk_lvl)) |-> (bclk_rise || bclk_fall));

    assert_mclk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[MCODE_W+BCODE_W] |=> !mclk_ce);

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_word |=> cfg_err);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_word |=> !cfg_err);

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (!mclk_ce && !bclk_lvl && !bclk_rise && !bclk_fall));

endmodule

bind audclk_divider audclk_divider_chk #(
    .MCODE_W (MCODE_W),
    .BCODE_W (BCODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .mclk_ce   (mclk_ce),
    .bclk_lvl  (bclk_lvl),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .cfg_err   (cfg_err),
    .state_q   (state_q)
);

// File: tb/audclk_divider_tb.sv
module audclk_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h91;
    logic       mclk_ce, bclk_lvl, bclk_rise, bclk_fall, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    audclk_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg),
        .mclk_ce   (mclk_ce),
        .bclk_lvl  (bclk_lvl),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .cfg_err   (cfg_err)
    );

    function automatic int mtab(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; 6: return 16; 7: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int btab(input int c);
        case (c)
            0: return 2;  1: return 4;  2: return 6;
            3: return 8;  4: return 12; 5: return 16;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: a single position inside the current frame.
    int  m_st = 0;          // 0 stopped-from-reset, 1 running, 2 fault
    int  m_mr = 1, m_br = 2, m_pos = 0, m_p = 2;
    bit  m_ill;
    bit  e_ce = 0, e_lvl = 0, e_rise = 0, e_fall = 0, e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0;
            e_ce = 0; e_lvl = 0; e_rise = 0; e_fall = 0; e_err = 0;
        end else begin
            m_ill = (mtab(int'(cfg[3:0])) == 0) || (btab(int'(cfg[6:4])) == 0);
            e_err = m_ill;
            if (m_st != 1) begin
                e_ce = 0; e_lvl = 0; e_rise = 0; e_fall = 0;
                if (!m_ill) begin
                    m_mr = mtab(int'(cfg[3:0])); m_br = btab(int'(cfg[6:4]));
                    m_pos = 0; m_st = 1;
                end else begin
                    m_st = 2;
                end
            end else begin
                m_p    = m_mr * m_br;
                e_ce   = ((m_pos % m_mr) == m_mr - 1) && cfg[7];
                e_rise = (m_pos == m_p / 2 - 1);
                e_fall = (m_pos == m_p - 1);
                if (e_rise) e_lvl = 1;
                if (e_fall) e_lvl = 0;
                if (m_pos == m_p - 1) begin
                    m_pos = 0;
                    if (m_ill) m_st = 2;
                    else begin
                        m_mr = mtab(int'(cfg[3:0])); m_br = btab(int'(cfg[6:4]));
                    end
                end else begin
                    m_pos++;
                end
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 mclk_ce vs model", int'(mclk_ce), int'(e_ce));
            chk("R3 bclk_lvl vs model", int'(bclk_lvl), int'(e_lvl));
            chk("R4 bclk_rise vs model", int'(bclk_rise), int'(e_rise));
            chk("R4 bclk_fall vs model", int'(bclk_fall), int'(e_fall));
            chk("R6 cfg_err vs model", int'(cfg_err), int'(e_err));
        end
    end

    function automatic bit sig(input int w);
        case (w)
            0: return mclk_ce;
            1: return bclk_rise;
            default: return bclk_fall;
        endcase
    endfunction

    // Waits for strobe 'from', then counts cycles until strobe 'to'.
    task automatic span(input int from, input int to, output int n);
        int guard = 0;
        while (!sig(from) && guard < 3000) begin
            @(negedge clk); guard++;
        end
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!sig(to) && n < 3000);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int g, hi, per, ces, edges;
        cyc(4);
        chk("R1 reset mclk_ce", int'(mclk_ce), 0);
        chk("R1 reset bclk_lvl", int'(bclk_lvl), 0);
        chk("R1 reset strobes", int'(bclk_rise | bclk_fall), 0);
        chk("R1 reset cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;
        cyc(50);

        // Sweep every master code, each with a different bit code.
        for (int c = 0; c < 8; c++) begin
            cfg = {1'b1, 3'(c % 6), 4'(c)};
            cyc(800);
            span(0, 0, g);
            chk($sformatf("R2 mclk gap code %0d", c), g, mtab(c));
            span(1, 2, hi);
            span(2, 1, per);
            chk($sformatf("R3 bclk high code %0d", c), hi, mtab(c) * btab(c % 6) / 2);
            chk($sformatf("R3 bclk low code %0d", c), per, mtab(c) * btab(c % 6) / 2);
        end

        // Master enable cleared: no strobes, bit clock keeps toggling.
        cfg = {1'b0, 3'd0, 4'd2};
        cyc(500);
        ces = 0; edges = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            ces += int'(mclk_ce);
            edges += int'(bclk_rise);
        end
        chk("R5 mclk_ce gated", ces, 0);
        chk("R5 bclk rises while gated", int'(edges == 25), 1);

        // Illegal master code.
        cfg = {1'b1, 3'd0, 4'd9};
        cyc(1);
        chk("R6 err on master code 9", int'(cfg_err), 1);
        cyc(400);
        edges = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            edges += int'(bclk_rise | bclk_fall | bclk_lvl | mclk_ce);
        end
        chk("R7 outputs static in fault", edges, 0);

        // Illegal bit code.
        cfg = {1'b1, 3'd7, 4'd0};
        cyc(1);
        chk("R6 err on bit code 7", int'(cfg_err), 1);

        // Recovery: M=6, B=2, frame of 12 cycles.
        cfg = {1'b1, 3'd0, 4'd3};
        g = 0;
        do begin
            @(negedge clk); g++;
        end while (!bclk_rise && g < 100);
        chk("R8 first rise after recovery", g, 7);
        chk("R6 err cleared", int'(cfg_err), 0);

        // Mid-period change to M=1, B=2 right after a rise.
        cyc(1);
        span(1, 1, g);
        cfg = {1'b1, 3'd0, 4'd0};
        hi = 0;
        do begin
            @(negedge clk); hi++;
        end while (!bclk_fall && hi < 100);
        chk("R9 old high kept", hi, 6);
        span(2, 1, per);
        chk("R9 new ratio after period end", per, 1);
        cyc(20);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule